// File: doc/BRIEF.md
# Pending Interrupt Preemption Selector

This block sits inside a processor's interrupt interface and decides, once per clock, whether a pending interrupt is urgent enough to preempt the code that is running. It considers two candidates. One is the best local private-peripheral interrupt. The other is the best interrupt offered by the external routing service. Each candidate has an identifier, a type code and a priority. A lower priority number means a more urgent interrupt. The priority value 32 is an idle code that means "nothing here".

For each security domain the block holds three inputs: an interface enable, a 5-bit priority mask and the highest active priority. A domain-select input chooses which set applies. The more urgent candidate is chosen, and a tie goes to the local one. That winner is then tested against the domain's running priority and its mask. The result is registered as a 64-bit status word and a priority. The word is zero exactly when nothing may preempt. Reading the outputs changes nothing.

Top module: `pend_preempt_sel`

## Requirements
- R1: While reset is asserted, `hppiWord` is zero and `hppiPrio` is 32 (the idle code).
- R2: The outputs are registered. A change on any input shows up on the outputs after the next rising clock edge, and not before it.
- R3: When the enable bit of the selected domain is 0, `hppiWord` is zero and `hppiPrio` is 32, whatever the candidates are.
- R4: The local candidate wins when `locPrio <= remPrio`. The remote candidate wins only when `remPrio < locPrio`.
- R5: The winner qualifies only if its priority is strictly below the running priority and is less than or equal to the selected domain's mask.
- R6: A winner whose priority is 32 or more never qualifies. If both candidates are idle, the outputs are zero and 32.
- R7: The running priority equals the domain's active priority when that value is below 32. Otherwise it is 32, so any non-idle winner passes the running-priority test.
- R8: When a winner qualifies, `hppiWord` carries the ID in bits [23:0], the type in bits [31:29] and 1 in bit 32, and `hppiPrio` carries its priority. Otherwise the word is zero and `hppiPrio` is 32. Bits [28:24] and [63:33] are always zero.
- R9: Only the domain chosen by `domSel` affects the result. The enable, mask and active priority of any other domain have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| domSel | input | 1 | Index of the domain under evaluation |
| locId | input | 24 | Local candidate identifier |
| locType | input | 3 | Local candidate type code |
| locPrio | input | 6 | Local candidate priority (32 = idle) |
| remId | input | 24 | Remote candidate identifier |
| remType | input | 3 | Remote candidate type code |
| remPrio | input | 6 | Remote candidate priority (32 = idle) |
| enVec | input | 2 | Interface enable, one bit per domain |
| maskVec | input | 10 | Priority mask, 5 bits per domain, domain 0 in the low bits |
| actVec | input | 12 | Highest active priority, 6 bits per domain, domain 0 in the low bits |
| hppiWord | output | 64 | Registered preemption status word |
| hppiPrio | output | 6 | Registered priority of the qualifying interrupt, or 32 |

## Verification
The main sweep runs every pair of candidate priorities from 0 to 32 against several running-priority values and several mask values. The running-priority values include 0, mid-range values, 31 and idle values of 32 and above. The mask values include 0 and 31. This sweep separates the tie rule from strict remote wins. It also separates the strict running-priority test from the inclusive mask test, and it shows how an idle active priority is treated. The sweep is repeated with each domain selected while the other domain holds opposite settings, which would expose a leak between domains. A separate pass holds the selected domain disabled. An explicit edge test shows that a new input reaches the outputs only after one clock edge.

// File: rtl/pend_sel_pkg.sv
package pend_sel_pkg;
  // strobes passed from the control decision to the datapath
  typedef struct packed {
    logic pickLocal;  // local candidate is the winner
    logic grant;      // winner may preempt
  } selStrobe_t;

  localparam int unsigned TYPE_LSB  = 29;
  localparam int unsigned VALID_BIT = 32;
endpackage

// File: rtl/pend_sel_ctrl.sv
module pend_sel_ctrl
  import pend_sel_pkg::*;
#(
  parameter int unsigned ND = 2,
  parameter int unsigned PW = 5,
  localparam int unsigned PIW = PW + 1,
  localparam int unsigned DW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic [DW-1:0]     domSel,
  input  logic [ND-1:0]     enVec,
  input  logic [ND*PW-1:0]  maskVec,
  input  logic [ND*PIW-1:0] actVec,
  input  logic [PIW-1:0]    locPrio,
  input  logic [PIW-1:0]    remPrio,
  output selStrobe_t        strobe
);
  localparam logic [PIW-1:0] IDLE = PIW'(1 << PW);

  logic [PW-1:0]  maskArr [ND];
  logic [PIW-1:0] runArr  [ND];

  // per-domain running priority: active value if real, idle otherwise
  for (genvar g = 0; g < ND; g++) begin : g_dom
    logic [PIW-1:0] actG;
    assign actG       = actVec[g*PIW +: PIW];
    assign maskArr[g] = maskVec[g*PW +: PW];
    assign runArr[g]  = (actG < IDLE) ? actG : IDLE;
  end

  logic           selEn;
  logic [PW-1:0]  selMask;
  logic [PIW-1:0] selRun;
  logic [PIW-1:0] bestPrio;
  logic           pickLocal;

  always_comb begin
    selEn   = 1'b0;
    selMask = '0;
    selRun  = IDLE;
    if (int'(domSel) < ND) begin
      selEn   = enVec[domSel];
      selMask = maskArr[domSel];
      selRun  = runArr[domSel];
    end
  end

  assign pickLocal = (locPrio <= remPrio);
  assign bestPrio  = pickLocal ? locPrio : remPrio;

  always_comb begin
    strobe.pickLocal = pickLocal;
    strobe.grant     = selEn
                     && (bestPrio < IDLE)
                     && (bestPrio <= {1'b0, selMask})
                     && (bestPrio < selRun);
  end
endmodule

// File: rtl/pend_sel_dp.sv
module pend_sel_dp
  import pend_sel_pkg::*;
#(
  parameter int unsigned IDW = 24,
  parameter int unsigned TW  = 3,
  parameter int unsigned PW  = 5,
  localparam int unsigned PIW = PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  selStrobe_t     strobe,
  input  logic [IDW-1:0] locId,
  input  logic [TW-1:0]  locType,
  input  logic [PIW-1:0] locPrio,
  input  logic [IDW-1:0] remId,
  input  logic [TW-1:0]  remType,
  input  logic [PIW-1:0] remPrio,
  output logic [63:0]    hppiWord,
  output logic [PIW-1:0] hppiPrio
);
  localparam logic [PIW-1:0] IDLE = PIW'(1 << PW);

  logic [IDW-1:0] winId;
  logic [TW-1:0]  winType;
  logic [PIW-1:0] winPrio;
  logic [63:0]    nextWord;
  logic [PIW-1:0] nextPrio;

  assign winId   = strobe.pickLocal ? locId   : remId;
  assign winType = strobe.pickLocal ? locType : remType;
  assign winPrio = strobe.pickLocal ? locPrio : remPrio;

  always_comb begin
    nextWord = '0;
    nextPrio = IDLE;
    if (strobe.grant) begin
      nextWord[IDW-1:0]         = winId;
      nextWord[TYPE_LSB +: TW]  = winType;
      nextWord[VALID_BIT]       = 1'b1;
      nextPrio                  = winPrio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hppiWord <= '0;
      hppiPrio <= IDLE;
    end else begin
      hppiWord <= nextWord;
      hppiPrio <= nextPrio;
    end
  end
endmodule

// File: rtl/pend_preempt_sel.sv
module pend_preempt_sel
  import pend_sel_pkg::*;
#(
  parameter int unsigned ND  = 2,
  parameter int unsigned IDW = 24,
  parameter int unsigned TW  = 3,
  parameter int unsigned PW  = 5,
  localparam int unsigned PIW = PW + 1,
  localparam int unsigned DW  = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     domSel,
  input  logic [IDW-1:0]    locId,
  input  logic [TW-1:0]     locType,
  input  logic [PIW-1:0]    locPrio,
  input  logic [IDW-1:0]    remId,
  input  logic [TW-1:0]     remType,
  input  logic [PIW-1:0]    remPrio,
  input  logic [ND-1:0]     enVec,
  input  logic [ND*PW-1:0]  maskVec,
  input  logic [ND*PIW-1:0] actVec,
  output logic [63:0]       hppiWord,
  output logic [PIW-1:0]    hppiPrio
);
  selStrobe_t strobe;

  pend_sel_ctrl #(.ND(ND), .PW(PW)) u_ctrl (
    .domSel (domSel),
    .enVec  (enVec),
    .maskVec(maskVec),
    .actVec (actVec),
    .locPrio(locPrio),
    .remPrio(remPrio),
    .strobe (strobe)
  );

  pend_sel_dp #(.IDW(IDW), .TW(TW), .PW(PW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .locId   (locId),
    .locType (locType),
    .locPrio (locPrio),
    .remId   (remId),
    .remType (remType),
    .remPrio (remPrio),
    .hppiWord(hppiWord),
    .hppiPrio(hppiPrio)
  );
endmodule

// File: rtl/pend_sel_chk.sv
module pend_sel_chk #(
  parameter int unsigned ND  = 2,
  parameter int unsigned IDW = 24,
  parameter int unsigned TW  = 3,
  parameter int unsigned PW  = 5,
  localparam int unsigned PIW = PW + 1,
  localparam int unsigned DW  = (ND > 1) ? $clog2(ND) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW-1:0]     domSel,
  input logic [IDW-1:0]    locId,
  input logic [PIW-1:0]    locPrio,
  input logic [PIW-1:0]    remPrio,
  input logic [ND-1:0]     enVec,
  input logic [ND*PW-1:0]  maskVec,
  input logic [ND*PIW-1:0] actVec,
  input logic [63:0]       hppiWord,
  input logic [PIW-1:0]    hppiPrio
);
  localparam logic [PIW-1:0] IDLE = PIW'(1 << PW);

  logic           cEn;
  logic [PIW-1:0] cMask;
  logic [PIW-1:0] cRun;
  logic [PIW-1:0] cAct;

  always_comb begin
    cEn   = 1'b0;
    cMask = '0;
    cAct  = IDLE;
    for (int d = 0; d < ND; d++) begin
      if (int'(domSel) == d) begin
        cEn   = enVec[d];
        cMask = {1'b0, maskVec[d*PW +: PW]};
        cAct  = actVec[d*PIW +: PIW];
      end
    end
    cRun = (cAct >= IDLE) ? IDLE : cAct;
  end

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hppiWord[63:33] == '0 && hppiWord[28:24] == '0);

  p_valid_matches_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hppiWord[32] == (hppiPrio != IDLE));

  p_invalid_word_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hppiWord[32] |-> hppiWord == '0);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cEn) |-> (hppiWord == '0 && hppiPrio == IDLE));

  p_qualify_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hppiWord[32] |-> (hppiPrio < $past(cRun) && hppiPrio <= $past(cMask)));

  p_tie_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(locPrio <= remPrio) && hppiWord[32])
      |-> (hppiWord[IDW-1:0] == $past(locId) && hppiPrio == $past(locPrio)));

  p_idle_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locPrio >= IDLE && remPrio >= IDLE) |-> !hppiWord[32]);
endmodule

bind pend_preempt_sel pend_sel_chk #(.ND(ND), .IDW(IDW), .TW(TW), .PW(PW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .domSel  (domSel),
  .locId   (locId),
  .locPrio (locPrio),
  .remPrio (remPrio),
  .enVec   (enVec),
  .maskVec (maskVec),
  .actVec  (actVec),
  .hppiWord(hppiWord),
  .hppiPrio(hppiPrio)
);

// File: tb/pend_preempt_sel_tb.sv
module pend_preempt_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:0]  domSel = '0;
  logic [23:0] locId = '0, remId = '0;
  logic [2:0]  locType = 3'd2, remType = 3'd5;
  logic [5:0]  locPrio = 6'd32, remPrio = 6'd32;
  logic [1:0]  enVec = '0;
  logic [9:0]  maskVec = '0;
  logic [11:0] actVec = '0;
  logic [63:0] hppiWord;
  logic [5:0]  hppiPrio;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pend_preempt_sel u_dut (
    .clk(clk), .rst_n(rst_n), .domSel(domSel),
    .locId(locId), .locType(locType), .locPrio(locPrio),
    .remId(remId), .remType(remType), .remPrio(remPrio),
    .enVec(enVec), .maskVec(maskVec), .actVec(actVec),
    .hppiWord(hppiWord), .hppiPrio(hppiPrio)
  );

  task automatic check(input string tag, input logic [63:0] gotW, input logic [63:0] expW,
                       input logic [5:0] gotP, input logic [5:0] expP);
    checks++;
    if (gotW !== expW || gotP !== expP) begin
      errs++;
      $display("FAIL %s: word=%h prio=%0d expected word=%h prio=%0d", tag, gotW, gotP, expW, expP);
    end
  endtask

  // independent model of the requirements
  task automatic model(input bit en, input int lp, input int rp, input int mask, input int act,
                       output logic [63:0] w, output logic [5:0] p);
    int run, bp;
    bit loc;
    run = (act < 32) ? act : 32;
    loc = (lp <= rp);
    bp  = loc ? lp : rp;
    w = '0;
    p = 6'd32;
    if (en && bp < 32 && bp <= mask && bp < run) begin
      w = (64'd1 << 32) | (64'(loc ? locType : remType) << 29) | 64'(loc ? locId : remId);
      p = 6'(bp);
    end
  endtask

  function automatic string tagOf(input bit en, input int lp, input int rp, input int act, input int dsel);
    if (!en) return "R3";
    if (lp >= 32 && rp >= 32) return "R6";
    if (lp == rp) return "R4";
    if (act >= 32) return "R7";
    if (dsel == 1) return "R9";
    return "R5";
  endfunction

  task automatic setDom(input int d, input bit en, input int mask, input int act);
    enVec[d] = en;
    maskVec[d*5 +: 5] = 5'(mask);
    actVec[d*6 +: 6] = 6'(act);
  endtask

  task automatic setCand(input int lp, input int rp);
    locPrio = 6'(lp);
    remPrio = 6'(rp);
    locId = {8'hA5, 16'(lp * 7 + 1)};
    remId = {8'h5A, 16'(rp * 11 + 3)};
  endtask

  initial begin
    int actList [6] = '{0, 5, 16, 31, 32, 40};
    int maskList [4] = '{0, 4, 16, 31};
    logic [63:0] ew;
    logic [5:0] ep;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", hppiWord, 64'd0, hppiPrio, 6'd32);
    rst_n = 1'b1;

    // R2: one-edge latency
    @(negedge clk);
    domSel = 1'b0;
    setDom(0, 1'b1, 31, 32);
    setCand(3, 9);
    #1 check("R2", hppiWord, 64'd0, hppiPrio, 6'd32);
    @(negedge clk);
    model(1'b1, 3, 9, 31, 32, ew, ep);
    check("R2", hppiWord, ew, hppiPrio, ep);

    // main sweep over each domain, other domain opposite settings
    for (int d = 0; d < 2; d++) begin
      for (int ai = 0; ai < 6; ai++) begin
        for (int mi = 0; mi < 4; mi++) begin
          for (int lp = 0; lp <= 32; lp++) begin
            for (int rp = 0; rp <= 32; rp++) begin
              domSel = 1'(d);
              setDom(d, 1'b1, maskList[mi], actList[ai]);
              setDom(1 - d, 1'b0, 31 - maskList[mi], 32);
              setCand(lp, rp);
              @(negedge clk);
              model(1'b1, lp, rp, maskList[mi], actList[ai], ew, ep);
              check(tagOf(1'b1, lp, rp, actList[ai], d), hppiWord, ew, hppiPrio, ep);
              checks++;
              if (hppiWord[63:33] != '0 || hppiWord[28:24] != '0) begin
                errs++;
                $display("FAIL R8: reserved bits word=%h expected zero", hppiWord);
              end
            end
          end
        end
      end
    end

    // selected domain disabled, other domain fully permissive
    for (int d = 0; d < 2; d++) begin
      for (int lp = 0; lp <= 32; lp++) begin
        for (int rp = 0; rp <= 32; rp++) begin
          domSel = 1'(d);
          setDom(d, 1'b0, 31, 32);
          setDom(1 - d, 1'b1, 31, 32);
          setCand(lp, rp);
          @(negedge clk);
          check("R3", hppiWord, 64'd0, hppiPrio, 6'd32);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R1: watchdog expired, got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule